// File: doc/BRIEF.md
# Serial Receive Engine with Standby Wakeup

This block recovers characters from an asynchronous serial line. It samples the line at sixteen times the bit rate, qualifies each start bit at its centre, and decides each data bit by a vote of three samples. It assembles characters of eight or nine bits and places each finished character in a one-deep receive buffer. It keeps four status flags: buffer full, overrun, framing error and idle line. It raises one interrupt request from these flags, according to two enables.

A standby bit puts the receiver to sleep, so that a node on a shared line can skip traffic meant for other nodes. While asleep the receiver still frames characters, but it discards them. A wake-select input chooses what ends standby. One choice is an idle line. The other is an address character, meaning a character whose top bit is 1. The address character that ends standby is kept as a normal character.

Frame control is a five-state machine. RX_IDLE moves to RX_START on a low sample. RX_START returns to RX_IDLE when the mid-bit vote is high (a false start) and moves on to RX_DATA when it is low. RX_DATA moves to RX_STOP after the last data bit. RX_STOP returns to RX_IDLE on a good stop bit and moves to RX_RECOVER on a bad one. RX_RECOVER returns to RX_IDLE once the line is high again. A low enable forces RX_IDLE from any state.

Top module: `sio_rx_wake`

## Requirements
- R1: The line is sampled on each `os_tick`, with 16 ticks per bit. A low level counts as a start only if the three-sample vote at mid start bit is low. Each data bit is the majority of three samples near its centre, so a pulse of 3 ticks or fewer is not a start, and a 1-tick spike inside a bit does not change that bit.
- R2: A character is sent LSB first. In 8-bit mode (`len9`=0), a received character loads `rx_data`, sets `data_full`, and reports `rx_bit9` as 0.
- R3: In 9-bit mode (`len9`=1), the ninth received bit appears on `rx_bit9` in the same cycle that the low eight bits load `rx_data`.
- R4: If the stop-bit sample is 0, `frame_err` is set in the same cycle that `data_full` is set. The character is still loaded.
- R5: If a character completes while `data_full` is set and no read is in progress, `overrun` is set. The buffered character and `data_full` are kept, and the new character is lost.
- R6: A one-cycle `rd_strobe` clears `data_full`, `overrun`, `frame_err` and `idle_flag`.
- R7: `idle_flag` is set after 10 consecutive bit times of high line in 8-bit mode, or 11 in 9-bit mode. It sets only once per high run.
- R8: `standby_set` sets `standby`. While `standby` is 1, a completed character that does not wake the receiver loads nothing and sets no flag.
- R9: When `wake_sel`=1, a character whose top bit is 1 clears `standby` and is accepted as a normal character. The top bit is bit 7 in 8-bit mode and the ninth bit in 9-bit mode.
- R10: When `wake_sel`=0, an idle-line detection during standby clears `standby` and does not set `idle_flag`.
- R11: While `rx_en`=0, no character is received, `irq` is 0, and the status flags keep their values.
- R12: `irq` is 1 when `rx_en` is 1 and either (`rx_irq_en` and (`data_full` or `overrun`)) or (`idle_irq_en` and `idle_flag`) holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversampling tick, 16 per bit |
| rx_pin | input | 1 | Serial line (asynchronous) |
| rx_en | input | 1 | Receiver enable |
| len9 | input | 1 | 1 = 9-bit characters |
| wake_sel | input | 1 | 1 = address-mark wakeup, 0 = idle wakeup |
| standby_set | input | 1 | Pulse that enters standby |
| rd_strobe | input | 1 | Buffer read pulse, clears flags |
| rx_irq_en | input | 1 | Enables the interrupt from full or overrun |
| idle_irq_en | input | 1 | Enables the interrupt from idle |
| rx_data | output | 8 | Buffered character, low eight bits |
| rx_bit9 | output | 1 | Ninth bit of the buffered character |
| data_full | output | 1 | Buffer holds an unread character |
| overrun | output | 1 | A character was lost |
| frame_err | output | 1 | Bad stop bit on the buffered character |
| idle_flag | output | 1 | Idle line detected |
| standby | output | 1 | Receiver is in standby |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps all 256 eight-bit values and a third of the nine-bit values. A wrong shift direction or bit count would scramble the data, and a lost ninth bit would show up on `rx_bit9`. It sends a short low glitch and a frame with a one-tick spike, which catch a receiver that starts or samples without voting. It probes the idle count on both sides of 10 and 11 bit times, where an off-by-one threshold would be exposed. The overrun case is checked for keeping the old byte. The standby cases check that discarded characters leave no trace, and that each wakeup path ends standby while the idle path leaves the idle flag clear.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_RECOVER
    } rx_state_e;

endpackage

// File: rtl/sio_rx_sampler.sv
module sio_rx_sampler #(
    parameter int VOTES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx_pin,
    output logic line_s,
    output logic vote
);
    localparam int HALF = VOTES / 2;

    logic             meta_q;
    logic             sync_q;
    logic [VOTES-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            hist_q <= '1;
        end else begin
            meta_q <= rx_pin;
            sync_q <= meta_q;
            if (tick) begin
                hist_q <= {hist_q[VOTES-2:0], sync_q};
            end
        end
    end

    assign line_s = sync_q;
    assign vote   = ($countones(hist_q) > HALF);

endmodule

// File: rtl/sio_rx_frame.sv
module sio_rx_frame
    import sio_rx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          enable,
    input  logic          len9,
    input  logic          line_s,
    input  logic          vote,
    output logic          done,
    output logic [DW-1:0] chr_data,
    output logic          chr_b9,
    output logic          chr_stop_ok,
    output logic          chr_nine
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(DW + 1);
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    rx_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [BW-1:0] idx_q;
    logic [DW:0]   sh_q;
    logic          mode9_q;
    logic [BW-1:0] last_idx;

    assign last_idx = mode9_q ? BW'(DW) : BW'(DW - 1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:    if (tick && !line_s) state_d = RX_START;
            RX_START:   if (tick && cnt_q == MID) state_d = vote ? RX_IDLE : RX_DATA;
            RX_DATA:    if (tick && cnt_q == LAST && idx_q == last_idx) state_d = RX_STOP;
            RX_STOP:    if (tick && cnt_q == LAST) state_d = vote ? RX_IDLE : RX_RECOVER;
            RX_RECOVER: if (tick && line_s) state_d = RX_IDLE;
            default:    state_d = RX_IDLE;
        endcase
        if (!enable) state_d = RX_IDLE;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            idx_q       <= '0;
            sh_q        <= '0;
            mode9_q     <= 1'b0;
            done        <= 1'b0;
            chr_data    <= '0;
            chr_b9      <= 1'b0;
            chr_stop_ok <= 1'b0;
            chr_nine    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    cnt_q <= '0;
                    idx_q <= '0;
                    if (tick && !line_s) mode9_q <= len9;
                end
                RX_START: begin
                    if (tick) cnt_q <= (cnt_q == MID) ? '0 : cnt_q + 1'b1;
                end
                RX_DATA: begin
                    if (tick) begin
                        if (cnt_q == LAST) begin
                            cnt_q <= '0;
                            sh_q  <= {vote, sh_q[DW:1]};
                            idx_q <= idx_q + 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (cnt_q == LAST) begin
                            cnt_q       <= '0;
                            done        <= enable;
                            chr_data    <= mode9_q ? sh_q[DW-1:0] : sh_q[DW:1];
                            chr_b9      <= mode9_q & sh_q[DW];
                            chr_stop_ok <= vote;
                            chr_nine    <= mode9_q;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                RX_RECOVER: cnt_q <= '0;
                default:    cnt_q <= '0;
            endcase
        end
    end

endmodule

// File: rtl/sio_rx_idle.sv
module sio_rx_idle #(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic enable,
    input  logic len9,
    input  logic line_s,
    output logic idle_hit
);
    localparam int T8 = (DW + 2) * OVS;
    localparam int T9 = (DW + 3) * OVS;
    localparam int IW = $clog2(T9 + 1);

    logic [IW-1:0] run_q;
    logic [IW-1:0] thr;

    assign thr = len9 ? IW'(T9) : IW'(T8);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= '0;
            idle_hit <= 1'b0;
        end else begin
            idle_hit <= enable && line_s && tick && (run_q == thr - 1'b1);
            if (!enable || !line_s) begin
                run_q <= '0;
            end else if (tick && run_q < thr) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sio_rx_status.sv
module sio_rx_status #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          done,
    input  logic [DW-1:0] chr_data,
    input  logic          chr_b9,
    input  logic          chr_stop_ok,
    input  logic          chr_nine,
    input  logic          idle_hit,
    input  logic          wake_sel,
    input  logic          standby_set,
    input  logic          rd_strobe,
    input  logic          rx_irq_en,
    input  logic          idle_irq_en,
    output logic [DW-1:0] rx_data,
    output logic          rx_bit9,
    output logic          data_full,
    output logic          overrun,
    output logic          frame_err,
    output logic          idle_flag,
    output logic          standby,
    output logic          irq
);
    logic msb;
    logic wake_addr;
    logic wake_idle;
    logic accept;
    logic busy;

    assign msb       = chr_nine ? chr_b9 : chr_data[DW-1];
    assign wake_addr = done && standby && wake_sel && msb;
    assign wake_idle = idle_hit && standby && !wake_sel;
    assign accept    = rx_en && done && (!standby || wake_addr);
    assign busy      = data_full && !rd_strobe;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data   <= '0;
            rx_bit9   <= 1'b0;
            data_full <= 1'b0;
            overrun   <= 1'b0;
            frame_err <= 1'b0;
            idle_flag <= 1'b0;
            standby   <= 1'b0;
        end else begin
            if (rd_strobe) begin
                data_full <= 1'b0;
                overrun   <= 1'b0;
                frame_err <= 1'b0;
                idle_flag <= 1'b0;
            end
            if (accept) begin
                if (busy) begin
                    overrun <= 1'b1;
                end else begin
                    rx_data   <= chr_data;
                    rx_bit9   <= chr_b9;
                    data_full <= 1'b1;
                    frame_err <= !chr_stop_ok;
                end
            end
            if (rx_en && idle_hit && !standby) idle_flag <= 1'b1;
            if (standby_set) begin
                standby <= 1'b1;
            end else if (rx_en && (wake_addr || wake_idle)) begin
                standby <= 1'b0;
            end
        end
    end

    assign irq = rx_en && ((rx_irq_en && (data_full || overrun)) ||
                           (idle_irq_en && idle_flag));

endmodule

// File: rtl/sio_rx_wake.sv
module sio_rx_wake #(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          rx_pin,
    input  logic          rx_en,
    input  logic          len9,
    input  logic          wake_sel,
    input  logic          standby_set,
    input  logic          rd_strobe,
    input  logic          rx_irq_en,
    input  logic          idle_irq_en,
    output logic [DW-1:0] rx_data,
    output logic          rx_bit9,
    output logic          data_full,
    output logic          overrun,
    output logic          frame_err,
    output logic          idle_flag,
    output logic          standby,
    output logic          irq
);
    logic          line_s;
    logic          vote;
    logic          done;
    logic [DW-1:0] chr_data;
    logic          chr_b9;
    logic          chr_stop_ok;
    logic          chr_nine;
    logic          idle_hit;

    sio_rx_sampler #(.VOTES(3)) samp_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (os_tick),
        .rx_pin (rx_pin),
        .line_s (line_s),
        .vote   (vote)
    );

    sio_rx_frame #(.OVS(OVS), .DW(DW)) frame_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (os_tick),
        .enable      (rx_en),
        .len9        (len9),
        .line_s      (line_s),
        .vote        (vote),
        .done        (done),
        .chr_data    (chr_data),
        .chr_b9      (chr_b9),
        .chr_stop_ok (chr_stop_ok),
        .chr_nine    (chr_nine)
    );

    sio_rx_idle #(.OVS(OVS), .DW(DW)) idle_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (os_tick),
        .enable   (rx_en),
        .len9     (len9),
        .line_s   (line_s),
        .idle_hit (idle_hit)
    );

    sio_rx_status #(.DW(DW)) stat_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_en       (rx_en),
        .done        (done),
        .chr_data    (chr_data),
        .chr_b9      (chr_b9),
        .chr_stop_ok (chr_stop_ok),
        .chr_nine    (chr_nine),
        .idle_hit    (idle_hit),
        .wake_sel    (wake_sel),
        .standby_set (standby_set),
        .rd_strobe   (rd_strobe),
        .rx_irq_en   (rx_irq_en),
        .idle_irq_en (idle_irq_en),
        .rx_data     (rx_data),
        .rx_bit9     (rx_bit9),
        .data_full   (data_full),
        .overrun     (overrun),
        .frame_err   (frame_err),
        .idle_flag   (idle_flag),
        .standby     (standby),
        .irq         (irq)
    );

endmodule

// File: rtl/sio_rx_wake_chk.sv
module sio_rx_wake_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_en,
    input logic          standby_set,
    input logic          rd_strobe,
    input logic [DW-1:0] rx_data,
    input logic          rx_bit9,
    input logic          data_full,
    input logic          overrun,
    input logic          frame_err,
    input logic          idle_flag,
    input logic          standby,
    input logic          irq
);
    assert_fe_with_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> data_full);

    assert_overrun_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> (data_full && $past(data_full)));

    assert_buffer_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_full && !rd_strobe) |=> ($stable(rx_data) && $stable(rx_bit9)));

    assert_rd_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !overrun);

    assert_standby_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && !standby_set) |=> (!$rose(data_full) || !standby));

    assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |-> !irq);

    assert_flags_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !rd_strobe) |=> $stable({data_full, overrun, frame_err, idle_flag}));

    assert_irq_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (data_full || overrun || idle_flag));

endmodule

bind sio_rx_wake sio_rx_wake_chk #(.DW(DW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_en       (rx_en),
    .standby_set (standby_set),
    .rd_strobe   (rd_strobe),
    .rx_data     (rx_data),
    .rx_bit9     (rx_bit9),
    .data_full   (data_full),
    .overrun     (overrun),
    .frame_err   (frame_err),
    .idle_flag   (idle_flag),
    .standby     (standby),
    .irq         (irq)
);

// File: tb/sio_rx_wake_tb_top.sv
`timescale 1ns/1ps
module sio_rx_wake_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b1;
    logic       rx_pin = 1'b1;
    logic       rx_en = 1'b1;
    logic       len9 = 1'b0;
    logic       wake_sel = 1'b0;
    logic       standby_set = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       rx_irq_en = 1'b0;
    logic       idle_irq_en = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9, data_full, overrun, frame_err, idle_flag, standby, irq;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    sio_rx_wake dut_i (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_pin(rx_pin),
        .rx_en(rx_en), .len9(len9), .wake_sel(wake_sel),
        .standby_set(standby_set), .rd_strobe(rd_strobe),
        .rx_irq_en(rx_irq_en), .idle_irq_en(idle_irq_en),
        .rx_data(rx_data), .rx_bit9(rx_bit9), .data_full(data_full),
        .overrun(overrun), .frame_err(frame_err), .idle_flag(idle_flag),
        .standby(standby), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [8:0] v, input bit nine, input bit stopv, input int spike);
        rx_pin = 1'b0;
        idle_cyc(16);
        for (int i = 0; i < (nine ? 9 : 8); i++) begin
            rx_pin = v[i];
            if (spike == i) begin
                idle_cyc(6);
                rx_pin = ~v[i];
                idle_cyc(1);
                rx_pin = v[i];
                idle_cyc(9);
            end else begin
                idle_cyc(16);
            end
        end
        rx_pin = stopv;
        idle_cyc(16);
        rx_pin = 1'b1;
    endtask

    task automatic rd();
        rd_strobe = 1'b1;
        idle_cyc(1);
        rd_strobe = 1'b0;
        idle_cyc(1);
    endtask

    task automatic pulse_standby();
        standby_set = 1'b1;
        idle_cyc(1);
        standby_set = 1'b0;
        idle_cyc(1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle_cyc(4);
        rst_n = 1'b1;
        idle_cyc(1);
        // reset values
        chk("R2 reset data_full", data_full, 0);
        chk("R6 reset flags", {overrun, frame_err, idle_flag}, 0);
        chk("R8 reset standby", standby, 0);
        chk("R12 reset irq", irq, 0);

        // R7: idle from reset, 8-bit threshold
        idle_cyc(139);
        chk("R7 idle not yet (8-bit)", idle_flag, 0);
        idle_cyc(40);
        chk("R7 idle set (8-bit)", idle_flag, 1);
        chk("R12 idle masked irq", irq, 0);
        idle_irq_en = 1'b1;
        idle_cyc(1);
        chk("R12 idle irq", irq, 1);
        rd();
        chk("R6 read clears idle", idle_flag, 0);
        chk("R12 irq drops", irq, 0);
        idle_irq_en = 1'b0;

        // R1: short glitch is not a start
        rx_pin = 1'b0;
        idle_cyc(3);
        rx_pin = 1'b1;
        idle_cyc(60);
        chk("R1 glitch rejected", data_full, 0);
        send(9'h0A5, 1'b0, 1'b1, 3);
        chk("R1 spike voted out", rx_data, 8'hA5);
        chk("R1 spike frame full", data_full, 1);
        rd();

        // R2: exhaustive 8-bit sweep
        for (int v = 0; v < 256; v++) begin
            send(9'(v), 1'b0, 1'b1, -1);
            chk("R2 full", data_full, 1);
            chk("R2 data", rx_data, v);
            chk("R2 bit9 zero", rx_bit9, 0);
            chk("R4 no framing err", frame_err, 0);
            rd();
            chk("R6 read clears full", data_full, 0);
        end

        // R3: 9-bit sweep
        len9 = 1'b1;
        for (int v = 0; v < 512; v += 3) begin
            send(9'(v), 1'b1, 1'b1, -1);
            chk("R3 data", rx_data, v & 8'hFF);
            chk("R3 ninth bit", rx_bit9, (v >> 8) & 1);
            rd();
        end
        len9 = 1'b0;

        // R4: framing error
        send(9'h03C, 1'b0, 1'b0, -1);
        chk("R4 framing err", frame_err, 1);
        chk("R4 full with err", data_full, 1);
        chk("R4 data kept", rx_data, 8'h3C);
        idle_cyc(20);
        rd();
        chk("R6 read clears fe", frame_err, 0);

        // R5: overrun
        send(9'h011, 1'b0, 1'b1, -1);
        send(9'h022, 1'b0, 1'b1, -1);
        chk("R5 overrun set", overrun, 1);
        chk("R5 full kept", data_full, 1);
        chk("R5 old data kept", rx_data, 8'h11);
        rx_irq_en = 1'b1;
        idle_cyc(1);
        chk("R12 rx irq", irq, 1);
        rd();
        chk("R6 read clears overrun", overrun, 0);
        chk("R6 read clears full", data_full, 0);
        send(9'h033, 1'b0, 1'b1, -1);
        chk("R5 next char after read", rx_data, 8'h33);
        chk("R5 no overrun", overrun, 0);
        rx_irq_en = 1'b0;
        idle_cyc(1);
        chk("R12 rx irq masked", irq, 0);
        rd();

        // R7: thresholds after a zero character
        send(9'h000, 1'b0, 1'b1, -1);
        rd();
        idle_cyc(132);
        chk("R7 8-bit below threshold", idle_flag, 0);
        idle_cyc(26);
        chk("R7 8-bit above threshold", idle_flag, 1);
        rd();
        len9 = 1'b1;
        send(9'h000, 1'b1, 1'b1, -1);
        rd();
        idle_cyc(150);
        chk("R7 9-bit below threshold", idle_flag, 0);
        idle_cyc(24);
        chk("R7 9-bit above threshold", idle_flag, 1);
        rd();
        len9 = 1'b0;

        // R8/R9: address-mark wakeup
        wake_sel = 1'b1;
        idle_cyc(200);
        rd();
        pulse_standby();
        chk("R8 standby set", standby, 1);
        send(9'h035, 1'b0, 1'b1, -1);
        chk("R8 discarded", data_full, 0);
        chk("R8 still standby", standby, 1);
        send(9'h09A, 1'b0, 1'b1, -1);
        chk("R9 woken", standby, 0);
        chk("R9 address accepted", data_full, 1);
        chk("R9 address data", rx_data, 8'h9A);
        rd();
        len9 = 1'b1;
        pulse_standby();
        send(9'h0FF, 1'b1, 1'b1, -1);
        chk("R8 9-bit discarded", data_full, 0);
        chk("R8 9-bit still standby", standby, 1);
        send(9'h155, 1'b1, 1'b1, -1);
        chk("R9 9-bit woken", standby, 0);
        chk("R9 9-bit data", rx_data, 8'h55);
        chk("R9 9-bit mark", rx_bit9, 1);
        rd();
        len9 = 1'b0;

        // R10: idle-line wakeup
        wake_sel = 1'b0;
        idle_cyc(200);
        rd();
        pulse_standby();
        send(9'h000, 1'b0, 1'b1, -1);
        chk("R8 idle-mode discard", data_full, 0);
        chk("R10 still standby", standby, 1);
        idle_cyc(200);
        chk("R10 woken by idle", standby, 0);
        chk("R10 no idle flag", idle_flag, 0);
        send(9'h042, 1'b0, 1'b1, -1);
        chk("R10 receives after wake", rx_data, 8'h42);
        chk("R10 full after wake", data_full, 1);
        rd();

        // R11: receiver disable
        rx_irq_en = 1'b1;
        send(9'h05E, 1'b0, 1'b1, -1);
        chk("R11 irq before disable", irq, 1);
        rx_en = 1'b0;
        idle_cyc(1);
        chk("R11 irq masked", irq, 0);
        chk("R11 full kept", data_full, 1);
        send(9'h077, 1'b0, 1'b1, -1);
        chk("R11 no reception", rx_data, 8'h5E);
        chk("R11 no overrun", overrun, 0);
        rx_en = 1'b1;
        idle_cyc(1);
        chk("R11 irq back", irq, 1);
        rd();
        rx_irq_en = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule